// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Less-Than

This block is a purely combinational 32-bit integer arithmetic and logic unit. It is built as a row of identical one-bit slices. Each slice holds three pieces: a conditional inverter on its B bit, a full adder, and a four-way result selector. The slice carries ripple from bit 0 upward. The carry into bit 0 is a pin, so an add, a subtract (invert B and carry in 1) or an increment come from one adder.

A signed less-than compare needs no extra subtractor. The top slice exports the sign bit of its adder sum as a set signal. That signal is routed back to the less input of bit 0, and the less inputs of every other slice are tied low. The result is therefore 1 or 0 in the lowest bit, with all upper bits clear.

The block also produces two flags. The overflow flag is taken from the carries entering and leaving the top slice. The zero flag reports an all-zero result. Data moves straight from operands to result with no handshake. The unit is meant to sit inside a datapath stage that registers its inputs and outputs.

Top module: `alu_slice_row`

## Requirements
- R1: With sel = 2'b00 the result is the bitwise AND of a and the effective B. The effective B is b when invert_b is 0 and ~b when invert_b is 1.
- R2: With sel = 2'b01 the result is the bitwise OR of a and the effective B.
- R3: With sel = 2'b10 the result is (a + effective B + carry_in) modulo 2^32. invert_b = 1 with carry_in = 1 therefore yields a − b.
- R4: overflow equals the carry into bit 31 XOR the carry out of bit 31. This is the same as signed overflow of the adder: both adder inputs have one sign and the sum has the other. overflow is driven from the adder for every sel value.
- R5: With sel = 2'b11, bit 0 of the result is bit 31 of the adder sum, and bits 31..1 are 0. With invert_b = 1 and carry_in = 1 this gives 1 when a − b has its sign bit set, with no correction for overflow. For example, a = 0x7FFFFFFF with b = 0xFFFFFFFF gives 1.
- R6: zero is 1 exactly when all 32 result bits are 0, for every sel value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand, before conditional inversion |
| invert_b | input | 1 | 1 complements b before the logic gates and the adder |
| carry_in | input | 1 | Carry into bit 0 of the adder |
| sel | input | 2 | Result select: 00 AND, 01 OR, 10 sum, 11 less-than |
| result | output | 32 | Selected result |
| overflow | output | 1 | Carry into top slice XOR carry out of top slice |
| zero | output | 1 | 1 when result is all zeros |

## Verification
The bound checker re-evaluates, whenever any operand or control changes, the relations that must hold for any input:
- the AND, OR and sum results against an independent sum of the operands;
- the overflow flag against the operand and sum signs;
- the cleared upper bits in less-than mode;
- the agreement between the zero flag and the result.

Only the bench scenarios show specific corner values:
- the overflow boundaries at 0x7FFFFFFF and 0x80000000;
- wrap-around to zero;
- equal operands in a compare;
- the raw-sign rule, which makes a compare with an overflowing difference report less-than.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } alu_sel_e;

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic     a_i,
  input  logic     b_i,
  input  logic     inv_b_i,
  input  logic     cin_i,
  input  logic     less_i,
  input  alu_sel_e sel_i,
  output logic     sum_o,
  output logic     cout_o,
  output logic     res_o
);

  logic b_eff;

  // conditional inverter ahead of both gates and adder
  assign b_eff = b_i ^ inv_b_i;

  // full adder
  assign sum_o  = a_i ^ b_eff ^ cin_i;
  assign cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);

  // four-way result selector
  always_comb begin
    unique case (sel_i)
      SEL_AND:  res_o = a_i & b_eff;
      SEL_OR:   res_o = a_i | b_eff;
      SEL_SUM:  res_o = sum_o;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] value_i,
  output logic         zero_o
);

  assign zero_o = ~|value_i;

endmodule

// File: rtl/alu_slice_row.sv
module alu_slice_row
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         invert_b,
  input  logic         carry_in,
  input  logic [1:0]   sel,
  output logic [W-1:0] result,
  output logic         overflow,
  output logic         zero
);

  localparam int MSB = W - 1;

  alu_sel_e sel_e;
  assign sel_e = alu_sel_e'(sel);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic ci;
    logic co;
    logic sm;
    logic rs;
    logic ls;

    if (i == 0) begin : g_lsb
      assign ci = carry_in;
      // sign of the top slice's sum loops back as the less-than bit
      assign ls = g_bit[MSB].sm;
    end else begin : g_upper
      assign ci = g_bit[i-1].co;
      assign ls = 1'b0;
    end

    alu_bit_slice u_slice (
      .a_i     (a[i]),
      .b_i     (b[i]),
      .inv_b_i (invert_b),
      .cin_i   (ci),
      .less_i  (ls),
      .sel_i   (sel_e),
      .sum_o   (sm),
      .cout_o  (co),
      .res_o   (rs)
    );

    assign result[i] = rs;
  end

  // overflow from carries around the top slice
  assign overflow = g_bit[MSB].ci ^ g_bit[MSB].co;

  alu_zero_detect #(.W(W)) u_zero (
    .value_i (result),
    .zero_o  (zero)
  );

endmodule

// File: rtl/alu_row_chk.sv
module alu_row_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         invert_b,
  input logic         carry_in,
  input logic [1:0]   sel,
  input logic [W-1:0] result,
  input logic         overflow,
  input logic         zero
);

  logic [W-1:0] bb;
  logic [W:0]   full;

  always_comb begin
    bb   = invert_b ? ~b : b;
    full = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, carry_in};

    if (sel == 2'b00) begin
      p_and_r1: assert (result == (a & bb))
        else $error("p_and_r1");
    end

    if (sel == 2'b01) begin
      p_or_r2: assert (result == (a | bb))
        else $error("p_or_r2");
    end

    if (sel == 2'b10) begin
      p_sum_r3: assert (result == full[W-1:0])
        else $error("p_sum_r3");
    end

    p_ovf_r4: assert (overflow ==
                      ((a[W-1] == bb[W-1]) && (full[W-1] != a[W-1])))
      else $error("p_ovf_r4");

    if (sel == 2'b11) begin
      p_slt_r5: assert (result == {{(W-1){1'b0}}, full[W-1]})
        else $error("p_slt_r5");
    end

    p_zero_r6: assert (zero == (result == '0))
      else $error("p_zero_r6");
  end

endmodule

bind alu_slice_row alu_row_chk #(.W(W)) u_chk (
  .a        (a),
  .b        (b),
  .invert_b (invert_b),
  .carry_in (carry_in),
  .sel      (sel),
  .result   (result),
  .overflow (overflow),
  .zero     (zero)
);

// File: tb/alu_slice_row_tb.sv
module alu_slice_row_tb;

  logic        clk;
  logic        rst_n;
  logic [31:0] a;
  logic [31:0] b;
  logic        invert_b;
  logic        carry_in;
  logic [1:0]  sel;
  logic [31:0] result;
  logic        overflow;
  logic        zero;

  int checks   = 0;
  int failures = 0;

  alu_slice_row #(.W(32)) u_dut (
    .a        (a),
    .b        (b),
    .invert_b (invert_b),
    .carry_in (carry_in),
    .sel      (sel),
    .result   (result),
    .overflow (overflow),
    .zero     (zero)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent reference from the requirements
  task automatic run_op(input string req, input logic [31:0] ta,
                        input logic [31:0] tb, input logic inv,
                        input logic cin, input logic [1:0] s);
    logic [31:0] bb;
    logic [32:0] sum;
    logic [31:0] er;
    logic        eo;
    @(negedge clk);
    a = ta; b = tb; invert_b = inv; carry_in = cin; sel = s;
    bb  = inv ? ~tb : tb;
    sum = {1'b0, ta} + {1'b0, bb} + {32'd0, cin};
    eo  = (ta[31] == bb[31]) && (sum[31] != ta[31]);
    case (s)
      2'b00:   er = ta & bb;
      2'b01:   er = ta | bb;
      2'b10:   er = sum[31:0];
      default: er = {31'd0, sum[31]};
    endcase
    #5;
    check(req, result, er);
    check("R4 overflow", {31'd0, overflow}, {31'd0, eo});
    check("R6 zero", {31'd0, zero}, {31'd0, (er == 32'd0)});
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    #5;
    check("R6 idle result", result, 32'd0);
    check("R6 idle zero", {31'd0, zero}, 32'd1);
    check("R4 idle overflow", {31'd0, overflow}, 32'd0);
  endtask

  task automatic t_logic;
    run_op("R1 and", 32'hF0F0_A5A5, 32'h0FF0_FFFF, 1'b0, 1'b0, 2'b00);
    run_op("R1 and inverted", 32'hF0F0_A5A5, 32'h0FF0_FFFF, 1'b1, 1'b0, 2'b00);
    run_op("R2 or", 32'h1234_0000, 32'h0000_5678, 1'b0, 1'b0, 2'b01);
    run_op("R2 or inverted", 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 2'b01);
  endtask

  task automatic t_add_sub;
    run_op("R3 add", 32'd1000, 32'd234, 1'b0, 1'b0, 2'b10);
    run_op("R3 add overflow", 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0, 2'b10);
    run_op("R3 add wrap", 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 2'b10);
    run_op("R3 sub", 32'd50, 32'd8, 1'b1, 1'b1, 2'b10);
    run_op("R3 sub overflow", 32'h8000_0000, 32'd1, 1'b1, 1'b1, 2'b10);
    run_op("R3 sub equal", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, 1'b1, 2'b10);
    run_op("R3 carry_in increment", 32'd41, 32'd0, 1'b0, 1'b1, 2'b10);
  endtask

  task automatic t_slt;
    run_op("R5 3<5", 32'd3, 32'd5, 1'b1, 1'b1, 2'b11);
    check("R5 3<5 is one", result, 32'd1);
    run_op("R5 5<3", 32'd5, 32'd3, 1'b1, 1'b1, 2'b11);
    check("R5 5<3 is zero", result, 32'd0);
    run_op("R5 -1<0", 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b1, 2'b11);
    run_op("R5 equal", 32'd77, 32'd77, 1'b1, 1'b1, 2'b11);
    run_op("R5 raw sign", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 2'b11);
    check("R5 raw sign no correction", result, 32'd1);
  endtask

  task automatic t_zero_flag;
    run_op("R6 and to zero", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 1'b0, 2'b00);
    run_op("R6 or nonzero", 32'd0, 32'h8000_0000, 1'b0, 1'b0, 2'b01);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      run_op("R3 R5 random", $urandom, $urandom, 1'($urandom),
             1'($urandom), 2'($urandom));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; invert_b = 1'b0; carry_in = 1'b0; sel = 2'b00;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_logic();
    t_add_sub();
    t_slt();
    t_zero_flag();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule